// File: doc/BRIEF.md
# UART Register Block with Receive Queue

This block is the register-side half of a simple serial port. A 32-bit word-addressed register bus on one side reads received bytes, sends bytes, inspects a status word and writes a control word. On the other side it sees a byte-wide receive stream and a byte-wide transmit stream. Serialisation, baud timing and line-error detection happen in a neighbouring block. That block feeds its overrun, frame and parity flags in as plain inputs, and they are shown in the status word.

Received bytes collect in a small queue. A bus read of the receive word hands out the oldest byte and removes it in the same cycle. The receive stream is valid/ready. `rx_ready` is high only while the queue has a free slot. A byte offered while it is low is thrown away. The transmit stream is also valid/ready. A write to the transmit word makes `tx_valid` high for exactly one cycle, and the block does not wait for `tx_ready`. Software must first check the transmit-full status bit, which is `tx_ready` inverted. A byte written while the sink is not ready is lost.

One sticky pending flag is held in the status word. It is set by any transmit write and by a non-empty receive queue. Only reset clears it. The interrupt pin is this flag gated by the control word's enable bit.

Top module: `uart_regif`

## Requirements
- R1: After synchronous reset the queue is empty, `rx_ready` is 1, the control word reads 0, the pending flag is 0, `irq` is 0 and `tx_valid` is 0. With `tx_ready`=1 and the error inputs at 0, the status word reads 0x00000004.
- R2: Word index = byte address >> 2. A read at index 0 (byte 0x0) returns the oldest queued byte in bits 7:0 (upper bits 0) during the read cycle, and at the clock edge it removes that byte when the queue is non-empty. Bytes come out in arrival order.
- R3: The queue holds DEPTH bytes. `rx_ready` = (occupancy < DEPTH). A byte offered with `rx_valid` while DEPTH bytes are held is discarded, and the held bytes and occupancy do not change.
- R4: A read at index 0 while the queue is empty returns the byte in the slot the next arrival would fill, and the occupancy stays 0.
- R5: Status word at index 2 (byte 0x8): bit0 = queue non-empty, bit1 = queue holds DEPTH bytes, bit2 = 1 (transmit side empty), bit3 = !`tx_ready`, bit4 = pending flag, bit5 = `err_overrun`, bit6 = `err_frame`, bit7 = `err_parity`, bits 31:8 = 0.
- R6: A write at index 3 (byte 0xC) stores all 32 bits of the control word, and a read at index 3 returns them.
- R7: A control write with bit1 set empties the queue: the occupancy and the write slot return to 0. This takes priority over an arrival in the same cycle.
- R8: A write at index 1 (byte 0x4) stores the 32-bit value, which is read back at index 1. In the next cycle `tx_valid` is 1 for one cycle with `tx_data` = written bits 7:0.
- R9: The pending flag (status bit4) is set by a transmit write and whenever the queue is non-empty after a clock edge. It stays set until reset.
- R10: `irq` = pending flag AND control bit4.
- R11: A write at index 2 has no effect on any status bit or other state.
- R12: Word indices above 3 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; pops the queue at index 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Queue has a free slot |
| tx_valid | output | 1 | One-cycle transmit pulse |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink can accept |
| err_overrun | input | 1 | Overrun flag from line side |
| err_frame | input | 1 | Frame error flag from line side |
| err_parity | input | 1 | Parity error flag from line side |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with DEPTH=8 and ADDR_W=6. With ADDR_W=6, byte addresses 0x10 to 0x3C exist, so the out-of-range decode can be exercised. With DEPTH=8, the queue wraps its write slot within a few dozen cycles, so stale-slot reads after a wrap, full-queue drops and arrivals that coincide with pops all occur often under random stimulus.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_RXD  = 2'd0,
    SEL_TXD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // status word bit positions
  localparam int ST_AVAIL   = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXFULL  = 3;
  localparam int ST_PEND    = 4;
  localparam int ST_OVR     = 5;
  localparam int ST_FRM     = 6;
  localparam int ST_PAR     = 7;

  // control word bit positions
  localparam int CT_TXCLR = 0;
  localparam int CT_RXCLR = 1;
  localparam int CT_IEN   = 4;
endpackage

// File: rtl/uart_regif_dec.sv
module uart_regif_dec
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              hit,
  output reg_sel_e          sel,
  output logic              wr_tx,
  output logic              wr_ctrl,
  output logic              rd_rx
);
  logic [ADDR_W-1:0] widx;

  assign widx    = addr >> 2;
  assign hit     = widx < ADDR_W'(4);
  assign sel     = reg_sel_e'(widx[1:0]);
  assign wr_tx   = wr & hit & (sel == SEL_TXD);
  assign wr_ctrl = wr & hit & (sel == SEL_CTRL);
  assign rd_rx   = rd & hit & (sel == SEL_RXD);
endmodule

// File: rtl/uart_regif_rxq.sv
module uart_regif_rxq #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         nz_next,
  output logic                         ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] occ_q, occ_d;
  logic          push_ok, pop_ok;
  int            slot;

  assign ready   = occ_q < CW'(DEPTH);
  assign push_ok = push & ready;
  assign pop_ok  = pop & (occ_q != '0);

  // oldest slot = write slot minus occupancy, modulo DEPTH
  always_comb begin
    slot = int'(wp) - int'(occ_q);
    if (slot < 0) slot = slot + DEPTH;
    rp = PW'(slot);
  end

  assign occ_d   = clr ? '0 : occ_q + CW'(push_ok) - CW'(pop_ok);
  assign nz_next = occ_d != '0;
  assign dout    = mem[rp];
  assign occ     = occ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      occ_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      occ_q <= occ_d;
      if (clr) begin
        wp <= '0;
      end else if (push_ok) begin
        mem[wp] <= din;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_regif_stat.sv
module uart_regif_stat
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic              nz_next,
  input  logic              q_nonempty,
  input  logic              q_full,
  input  logic              tx_ready,
  input  logic              err_overrun,
  input  logic              err_frame,
  input  logic              err_parity,
  input  logic              irq_en,
  output logic [WORD_W-1:0] status,
  output logic              pend,
  output logic              irq
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)                   pend_q <= 1'b0;
    else if (tx_wr || nz_next) pend_q <= 1'b1;
  end

  always_comb begin
    status             = '0;
    status[ST_AVAIL]   = q_nonempty;
    status[ST_RXFULL]  = q_full;
    status[ST_TXEMPTY] = 1'b1;
    status[ST_TXFULL]  = ~tx_ready;
    status[ST_PEND]    = pend_q;
    status[ST_OVR]     = err_overrun;
    status[ST_FRM]     = err_frame;
    status[ST_PAR]     = err_parity;
  end

  assign pend = pend_q;
  assign irq  = pend_q & irq_en;
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              err_overrun,
  input  logic              err_frame,
  input  logic              err_parity,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              hit, wr_tx, wr_ctrl, rd_rx, rx_clr;
  reg_sel_e          sel;
  logic [BYTE_W-1:0] q_dout;
  logic [CW-1:0]     rx_occ;
  logic              nz_next, pend_q, irq_en;
  logic [WORD_W-1:0] status_w, ctrl_q, txd_q;
  logic              tx_valid_q;
  logic [BYTE_W-1:0] tx_data_q;

  uart_regif_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .hit(hit), .sel(sel), .wr_tx(wr_tx), .wr_ctrl(wr_ctrl), .rd_rx(rd_rx)
  );

  assign rx_clr = wr_ctrl & bus_wdata[CT_RXCLR];

  uart_regif_rxq #(.DEPTH(DEPTH), .DW(BYTE_W)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_valid), .din(rx_data), .pop(rd_rx),
    .dout(q_dout), .occ(rx_occ), .nz_next(nz_next), .ready(rx_ready)
  );

  assign irq_en = ctrl_q[CT_IEN];

  uart_regif_stat u_stat (
    .clk(clk), .rst(rst), .tx_wr(wr_tx), .nz_next(nz_next),
    .q_nonempty(rx_occ != '0), .q_full(rx_occ == CW'(DEPTH)),
    .tx_ready(tx_ready), .err_overrun(err_overrun), .err_frame(err_frame),
    .err_parity(err_parity), .irq_en(irq_en),
    .status(status_w), .pend(pend_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      txd_q      <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= wr_tx;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_tx) begin
        txd_q     <= bus_wdata;
        tx_data_q <= bus_wdata[BYTE_W-1:0];
      end
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_RXD:  bus_rdata = {{(WORD_W-BYTE_W){1'b0}}, q_dout};
        SEL_TXD:  bus_rdata = txd_q;
        SEL_STAT: bus_rdata = status_w;
        SEL_CTRL: bus_rdata = ctrl_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic                       wbit1,
  input logic                       tx_valid,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic                       pend,
  input logic                       ien
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [ADDR_W-1:0] widx;
  logic wr_tx, rxclr, pop_try;

  assign widx    = bus_addr >> 2;
  assign wr_tx   = bus_wr && (widx == ADDR_W'(1));
  assign rxclr   = bus_wr && (widx == ADDR_W'(3)) && wbit1;
  assign pop_try = bus_rd && (widx == ADDR_W'(0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH) && !pop_try && !rxclr) |=> occ == CW'(DEPTH));
  p_rx_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rxclr |=> occ == '0);
  p_tx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> tx_valid);
  p_tx_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_tx |=> !tx_valid);
  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    pend |=> pend);
  p_pend_queue_r9: assert property (@(posedge clk) disable iff (rst)
    (occ != '0) |-> pend);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend && ien));
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .wbit1(bus_wdata[1]), .tx_valid(tx_valid), .irq(irq),
  .occ(rx_occ), .pend(pend_q), .ien(irq_en)
);

// File: tb/sim_uart_regif.sv
`timescale 1ns/1ps
module sim_uart_regif;
  localparam int AW = 6;
  localparam int DP = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] bus_addr;
  logic          bus_wr, bus_rd;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          rx_valid, rx_ready, tx_valid, tx_ready, irq;
  logic [7:0]    rx_data, tx_data;
  logic          err_overrun, err_frame, err_parity;

  int n_run = 0;
  int n_bad = 0;

  // reference state
  logic [7:0]  m_mem [DP];
  int          m_wp, m_cnt;
  logic        m_pend;
  logic [31:0] m_ctrl, m_tx;
  logic        e_txv;
  logic [7:0]  e_txd;

  always #10 clk = ~clk;

  uart_regif #(.ADDR_W(AW), .DEPTH(DP)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .err_overrun(err_overrun), .err_frame(err_frame),
    .err_parity(err_parity), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int idx);
    logic [31:0] s;
    case (idx)
      0: return {24'd0, m_mem[(m_wp - m_cnt + DP) % DP]};
      1: return m_tx;
      2: begin
        s = 32'd0;
        s[0] = (m_cnt != 0); s[1] = (m_cnt == DP); s[2] = 1'b1; s[3] = ~tx_ready;
        s[4] = m_pend; s[5] = err_overrun; s[6] = err_frame; s[7] = err_parity;
        return s;
      end
      3: return m_ctrl;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R2";
      1: return "R8";
      2: return "R5";
      3: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DP; i++) m_mem[i] = 8'd0;
    m_wp = 0; m_cnt = 0; m_pend = 1'b0; m_ctrl = 32'd0; m_tx = 32'd0;
    e_txv = 1'b0; e_txd = 8'd0;
  endtask

  task automatic op(input bit wr, input bit rd, input logic [AW-1:0] a, input logic [31:0] wd,
                    input bit rxv, input logic [7:0] rxd, input bit txr, input logic [2:0] errs,
                    input string tag);
    int idx;
    bit push, pop, clr, txw;
    idx = int'(a >> 2);
    @(negedge clk);
    chk(tx_valid === e_txv, "R8", {31'd0, tx_valid}, {31'd0, e_txv});
    if (e_txv) chk(tx_data === e_txd, "R8", {24'd0, tx_data}, {24'd0, e_txd});
    chk(irq === (m_pend & m_ctrl[4]), "R10", {31'd0, irq}, {31'd0, m_pend & m_ctrl[4]});
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    rx_valid = rxv; rx_data = rxd; tx_ready = txr;
    {err_parity, err_frame, err_overrun} = errs;
    #2;
    chk(rx_ready === (m_cnt < DP), "R3", {31'd0, rx_ready}, {31'd0, m_cnt < DP});
    if (rd) chk(bus_rdata === exp_rd(idx), (tag == "") ? tag_of(idx) : tag, bus_rdata, exp_rd(idx));
    @(posedge clk);
    push = rxv && (m_cnt < DP);
    pop  = rd && (idx == 0) && (m_cnt != 0);
    clr  = wr && (idx == 3) && wd[1];
    txw  = wr && (idx == 1);
    e_txv = txw;
    if (txw) begin m_tx = wd; e_txd = wd[7:0]; end
    if (wr && idx == 3) m_ctrl = wd;
    if (clr) begin
      m_wp = 0; m_cnt = 0;
    end else begin
      if (push) begin m_mem[m_wp] = rxd; m_wp = (m_wp + 1) % DP; end
      m_cnt = m_cnt + int'(push) - int'(pop);
    end
    if (txw || m_cnt != 0) m_pend = 1'b1;
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic rd_at(input logic [AW-1:0] a, input string tag);
    op(1'b0, 1'b1, a, 32'd0, 1'b0, 8'd0, 1'b1, 3'd0, tag);
  endtask
  task automatic wr_at(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    op(1'b1, 1'b0, a, d, 1'b0, 8'd0, 1'b1, 3'd0, tag);
  endtask
  task automatic rx_in(input logic [7:0] d, input string tag);
    op(1'b0, 1'b0, '0, 32'd0, 1'b1, d, 1'b1, 3'd0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin : main
    int a_sel;
    logic [AW-1:0] ra;
    void'($urandom(32'd4242));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 0; rx_data = '0; tx_ready = 1'b1;
    err_overrun = 0; err_frame = 0; err_parity = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd_at(6'h08, "R1");
    rd_at(6'h0C, "R1");
    chk(irq === 1'b0 && tx_valid === 1'b0, "R1", {30'd0, irq, tx_valid}, 32'd0);

    // R10 enable first so the queue-driven pending shows on irq; R9 set by arrival
    wr_at(6'h0C, 32'h0000_0010, "R6");
    rx_in(8'hA1, "R9"); rx_in(8'hB2, "R2"); rx_in(8'hC3, "R2");
    rd_at(6'h08, "R9");
    rd_at(6'h00, "R2"); rd_at(6'h00, "R2"); rd_at(6'h00, "R2");
    rd_at(6'h08, "R9");   // pending stays after drain

    // R3 fill, drop one, drain; slots wrap
    for (int i = 0; i < DP; i++) rx_in(8'h10 + 8'(i), "R3");
    rd_at(6'h08, "R5");
    rx_in(8'hEE, "R3");
    for (int i = 0; i < DP; i++) rd_at(6'h00, "R3");

    // R4 empty read returns the stale slot and keeps count 0
    rd_at(6'h00, "R4");
    rd_at(6'h08, "R4");

    // R7 receive clear wins over same-cycle arrival
    rx_in(8'h55, "R7"); rx_in(8'h66, "R7");
    op(1'b1, 1'b0, 6'h0C, 32'h0000_0012, 1'b1, 8'h77, 1'b1, 3'd0, "R7");
    rd_at(6'h08, "R7");
    rx_in(8'h88, "R7");
    rd_at(6'h00, "R7");

    // R8 transmit pulse and readback
    wr_at(6'h04, 32'hDEAD_BE5A, "R8");
    rd_at(6'h04, "R8");

    // R11 status write ignored
    op(1'b1, 1'b0, 6'h08, 32'hFFFF_FFFF, 1'b0, 8'd0, 1'b0, 3'b101, "R11");
    op(1'b0, 1'b1, 6'h08, 32'd0, 1'b0, 8'd0, 1'b0, 3'b101, "R11");

    // R12 out-of-range
    wr_at(6'h10, 32'h1234_5678, "R12");
    rd_at(6'h10, "R12");
    rd_at(6'h0C, "R12");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      a_sel = int'($urandom % 6);
      case (a_sel)
        0: ra = 6'h00;
        1: ra = 6'h04;
        2: ra = 6'h08;
        3: ra = 6'h0C;
        4: ra = 6'h14;
        default: ra = 6'h3C;
      endcase
      op(($urandom % 4) == 0, ($urandom % 2) == 0, ra,
         (ra == 6'h0C && ($urandom % 8) != 0) ? ($urandom & 32'hFFFF_FFFD) : $urandom,
         ($urandom % 3) != 0, 8'($urandom), ($urandom % 4) != 0, 3'($urandom), "");
    end

    @(negedge clk);
    chk(tx_valid === e_txv, "R8", {31'd0, tx_valid}, {31'd0, e_txv});
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule